// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeper

This block holds the time of day and the calendar as seven packed-BCD byte registers and advances them once per second. The second comes from a divider that counts pulses of a 32.768 kHz clock-enable input. The hours register can run in either a 12-hour or a 24-hour format. A clock-halt bit in the seconds register stops all timekeeping.

A serial front end never touches the running registers directly. It works through a set of user buffer registers. A one-cycle begin pulse marks the start of a transfer and copies the running registers into the buffers, so every read in that transfer sees one consistent instant. Writes made during the transfer go into the buffers. A one-cycle finish pulse marks the end of the transfer, and at that pulse only the registers that were written are copied back. All other registers keep counting. Committing a seconds value also restarts the sub-second divider.

Top module: `bcd_timekeeper`

## Requirements
- R1: Register index map: 0 holds seconds, with bit 7 as the halt flag. 1 holds minutes, 2 hours, 3 date, 4 month, 5 day-of-week and 6 year. Index 7 reads as 0x00 and writes to it are dropped.
- R2: After reset the registers read year 00, day-of-week 01, month 01, date 01, hours 0x00 (24-hour), minutes 00 and seconds 00, with the clock running.
- R3: A one-second tick occurs every DIV_RATIO enable pulses (default 32768). Seconds and minutes count in BCD from 00 to 59, wrap to 00 and carry into the next register.
- R4: When hours bit 7 is 0 (24-hour mode), the hour counts 00 to 23 in BCD, with bit 5 as the tens-of-hours 2 digit. The step from 23:59:59 gives 00:00:00 and advances the day.
- R5: When hours bit 7 is 1 (12-hour mode), bits 4:0 count 12, 01 … 11 and bit 5 is PM when 1. Bit 5 toggles when 11 becomes 12. PM 11:59:59 goes to AM 12:00:00 and advances the day. AM 11:59:59 does not advance the day.
- R6: A day advance steps day-of-week from 7 back to 1. The date wraps after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the others, and for month 02, 29 when the BCD year is a multiple of 4 and 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: A begin pulse copies all running registers into the buffers. Reads return buffer contents, so ticks during a transfer do not change what is read.
- R8: A write during a transfer updates the buffer, and the new value is readable at once. At the finish pulse only the written registers are copied into the running registers, and unwritten registers keep their running values.
- R9: Writes outside a transfer (no begin pulse since the last finish) change no register.
- R10: Committing a seconds value resets the divider, so the next tick comes after exactly DIV_RATIO further enable pulses.
- R11: While seconds bit 7 is 1, the divider and all counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse at 32.768 kHz rate |
| xfer_begin | input | 1 | One-cycle pulse at transfer start; loads buffers |
| xfer_finish | input | 1 | One-cycle pulse at transfer end; commits written buffers |
| buf_wr | input | 1 | Write strobe into the buffer selected by buf_addr |
| buf_addr | input | 3 | Register index for read and write |
| buf_wdata | input | 8 | Write data |
| buf_rdata | output | 8 | Buffer contents at buf_addr (combinational) |

## Verification
A wrong carry or wrap shows only at the next transfer that reads the buffers. A bad rollover is seen one tick after the boundary is crossed, so each vector starts one tick or a few ticks short of a rollover. A divider that keeps its phase across a seconds commit, or that ignores the halt flag, shows as a seconds value that is off by one within one DIV_RATIO window. Dirty-mask faults show at the first read after a finish pulse, as a register that was overwritten or that stopped counting.

// File: rtl/tk_pkg.sv
// Package: shared types, register indices and BCD helpers for the timekeeper.
// Assumes register contents are legal packed BCD; illegal values give undefined carries.
package tk_pkg;

    localparam int unsigned NREG   = 7;
    localparam int unsigned ADDR_W = 3;

    localparam int unsigned IDX_SEC  = 0;
    localparam int unsigned IDX_MIN  = 1;
    localparam int unsigned IDX_HOUR = 2;
    localparam int unsigned IDX_DATE = 3;
    localparam int unsigned IDX_MON  = 4;
    localparam int unsigned IDX_DOW  = 5;
    localparam int unsigned IDX_YEAR = 6;

    typedef logic [NREG-1:0][7:0] regfile_t;

    // year, dow, month, date, hours, minutes, seconds (index 6 down to 0)
    localparam regfile_t RESET_VAL = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Add one to a two-digit packed BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Last date of a month in BCD; leap test uses 10 == 2 (mod 4).
    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic       yr_tens_odd,
                                              input logic [3:0] yr_ones);
        logic leap;
        if (yr_tens_odd)
            leap = (yr_ones == 4'h2) || (yr_ones == 4'h6);
        else
            leap = (yr_ones == 4'h0) || (yr_ones == 4'h4) || (yr_ones == 4'h8);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/tk_second_divider.sv
// Module: divides the 32.768 kHz enable down to a one-cycle tick per second.
// Assumes osc_en is a single-cycle pulse; halt freezes the count, restart zeroes it.
module tk_second_divider #(
    parameter int unsigned DIV_RATIO = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic halt,
    input  logic restart,
    output logic sec_tick
);
    localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt;

    // Count enable pulses while running; zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (osc_en && !halt)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Emit the tick on the enable that completes a full second.
    assign sec_tick = osc_en && !halt && !restart && (cnt == LAST);

    // R11: a halted divider keeps its phase
    a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !restart |=> $stable(cnt));

endmodule

// File: rtl/tk_calendar_step.sv
// Module: combinational next-second value of the full time/date register set.
// Assumes legal BCD input; hours bit 7 selects 12-hour format, bit 5 then means PM.
module tk_calendar_step
    import tk_pkg::*;
(
    input  regfile_t cur,
    output regfile_t nxt
);
    logic [7:0] s_inc, m_inc, h12_inc, h24_inc, d_inc, mo_inc, y_inc, w_inc, last_day;
    logic       roll_min, roll_hr, roll_day;

    assign s_inc    = bcd_inc({1'b0, cur[IDX_SEC][6:0]});
    assign m_inc    = bcd_inc(cur[IDX_MIN]);
    assign h12_inc  = bcd_inc({3'b000, cur[IDX_HOUR][4:0]});
    assign h24_inc  = bcd_inc({1'b0, cur[IDX_HOUR][6:0]});
    assign d_inc    = bcd_inc(cur[IDX_DATE]);
    assign mo_inc   = bcd_inc(cur[IDX_MON]);
    assign y_inc    = bcd_inc(cur[IDX_YEAR]);
    assign w_inc    = bcd_inc(cur[IDX_DOW]);
    assign last_day = month_last(cur[IDX_MON], cur[IDX_YEAR][4], cur[IDX_YEAR][3:0]);

    // Ripple the one-second carry through seconds, minutes, hours and the calendar.
    always_comb begin
        nxt      = cur;
        roll_day = 1'b0;
        roll_min = (cur[IDX_SEC][6:0] == 7'h59);
        nxt[IDX_SEC] = roll_min ? {cur[IDX_SEC][7], 7'h00} : (s_inc | {cur[IDX_SEC][7], 7'h00});
        roll_hr  = roll_min && (cur[IDX_MIN] == 8'h59);
        if (roll_min)
            nxt[IDX_MIN] = (cur[IDX_MIN] == 8'h59) ? 8'h00 : m_inc;
        if (roll_hr) begin
            if (cur[IDX_HOUR][7]) begin
                if (cur[IDX_HOUR][4:0] == 5'h12) begin
                    nxt[IDX_HOUR] = {2'b10, cur[IDX_HOUR][5], 5'h01};
                end else if (cur[IDX_HOUR][4:0] == 5'h11) begin
                    nxt[IDX_HOUR] = {2'b10, ~cur[IDX_HOUR][5], 5'h12};
                    roll_day      = cur[IDX_HOUR][5];
                end else begin
                    nxt[IDX_HOUR] = {2'b10, cur[IDX_HOUR][5], 5'h00} | h12_inc;
                end
            end else begin
                if (cur[IDX_HOUR][6:0] == 7'h23) begin
                    nxt[IDX_HOUR] = 8'h00;
                    roll_day      = 1'b1;
                end else begin
                    nxt[IDX_HOUR] = h24_inc;
                end
            end
        end
        if (roll_day) begin
            nxt[IDX_DOW] = (cur[IDX_DOW] == 8'h07) ? 8'h01 : w_inc;
            if (cur[IDX_DATE] == last_day) begin
                nxt[IDX_DATE] = 8'h01;
                if (cur[IDX_MON] == 8'h12) begin
                    nxt[IDX_MON]  = 8'h01;
                    nxt[IDX_YEAR] = (cur[IDX_YEAR] == 8'h99) ? 8'h00 : y_inc;
                end else begin
                    nxt[IDX_MON] = mo_inc;
                end
            end else begin
                nxt[IDX_DATE] = d_inc;
            end
        end
    end

endmodule

// File: rtl/tk_user_buffer.sv
// Module: user-side buffer set with per-register written flags.
// Assumes begin/finish are single-cycle pulses; begin wins over a same-cycle write.
module tk_user_buffer
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_begin,
    input  logic              xfer_finish,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  regfile_t          live,
    output regfile_t          shadow,
    output logic [NREG-1:0]   dirty,
    output logic [7:0]        rdata
);
    logic active;
    logic addr_ok;

    assign addr_ok = (addr < ADDR_W'(NREG));

    // Snapshot on begin, capture writes while active, close on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= RESET_VAL;
            dirty  <= '0;
            active <= 1'b0;
        end else if (xfer_begin) begin
            shadow <= live;
            dirty  <= '0;
            active <= 1'b1;
        end else if (xfer_finish) begin
            dirty  <= '0;
            active <= 1'b0;
        end else if (active && wr_en && addr_ok) begin
            shadow[addr] <= wdata;
            dirty[addr]  <= 1'b1;
        end
    end

    // Serve reads from the buffer; unmapped index returns zero.
    assign rdata = addr_ok ? shadow[addr] : 8'h00;

    // R9: no buffer change outside a transfer
    a_r9_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !xfer_begin |=> $stable(shadow));

endmodule

// File: rtl/bcd_timekeeper.sv
// Module: top of the BCD clock-calendar; running registers, divider, step logic, buffers.
// Assumes osc_en, xfer_begin and xfer_finish are single-cycle pulses in the clk domain.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              xfer_begin,
    input  logic              xfer_finish,
    input  logic              buf_wr,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata
);
    regfile_t        live, adv, shadow;
    logic [NREG-1:0] dirty;
    logic            sec_tick, halt, commit_sec;

    assign halt       = live[IDX_SEC][7];
    assign commit_sec = xfer_finish && dirty[IDX_SEC];

    tk_second_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .halt     (halt),
        .restart  (commit_sec),
        .sec_tick (sec_tick)
    );

    tk_calendar_step u_step (
        .cur (live),
        .nxt (adv)
    );

    tk_user_buffer u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_begin  (xfer_begin),
        .xfer_finish (xfer_finish),
        .wr_en       (buf_wr),
        .addr        (buf_addr),
        .wdata       (buf_wdata),
        .live        (live),
        .shadow      (shadow),
        .dirty       (dirty),
        .rdata       (buf_rdata)
    );

    // Per register: committed buffer value wins, otherwise advance on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= RESET_VAL;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (xfer_finish && dirty[i])
                    live[i] <= shadow[i];
                else if (sec_tick)
                    live[i] <= adv[i];
            end
        end
    end

    // R11: halted time does not move except by commit
    a_r11_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !(xfer_finish && (|dirty)) |=> $stable(live));

    // R7: the buffers hold the running values seen at the begin pulse
    a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_begin |=> (shadow == $past(live)));

    // R10: a seconds commit restarts the divider, no tick right after
    a_r10_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV_RATIO > 1) && commit_sec |=> !sec_tick);

    // R8: each written buffer lands in its running register at the finish pulse
    for (genvar g = 0; g < NREG; g++) begin : g_commit_chk
        a_r8_commit: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_finish && dirty[g] |=> (live[g] == $past(shadow[g])));
    end

endmodule

// File: tb/tb_bcd_timekeeper.sv
module tb_bcd_timekeeper;
    localparam int DIV = 4;

    typedef struct packed {
        logic [55:0] init;
        logic [7:0]  n;
        logic [3:0]  req;
        logic [55:0] exp;
    } vec_t;

    // Byte order in each constant: year dow month date hours minutes seconds
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{56'h24_01_01_01_00_00_00, 8'd1, 4'd3, 56'h24_01_01_01_00_00_01}, // R3 simple tick
        '{56'h24_02_03_15_10_59_59, 8'd1, 4'd4, 56'h24_02_03_15_11_00_00}, // R4 hour carry
        '{56'h99_07_12_31_23_59_59, 8'd1, 4'd6, 56'h00_01_01_01_00_00_00}, // R6 full wrap
        '{56'h16_03_02_28_23_59_59, 8'd1, 4'd6, 56'h16_04_02_29_00_00_00}, // R6 leap odd tens
        '{56'h23_03_02_28_23_59_59, 8'd1, 4'd6, 56'h23_04_03_01_00_00_00}, // R6 common year
        '{56'h24_05_02_29_23_59_59, 8'd1, 4'd6, 56'h24_06_03_01_00_00_00}, // R6 leap end
        '{56'h12_06_04_30_23_59_59, 8'd1, 4'd6, 56'h12_07_05_01_00_00_00}, // R6 30-day month
        '{56'h30_02_09_30_23_59_59, 8'd1, 4'd6, 56'h30_03_10_01_00_00_00}, // R6 month digit
        '{56'h21_04_06_10_91_59_59, 8'd1, 4'd5, 56'h21_04_06_10_B2_00_00}, // R5 AM to PM
        '{56'h21_03_06_15_B1_59_59, 8'd1, 4'd5, 56'h21_04_06_16_92_00_00}, // R5 midnight
        '{56'h21_03_06_15_B2_59_59, 8'd1, 4'd5, 56'h21_03_06_15_A1_00_00}, // R5 12 to 1
        '{56'h05_02_07_04_09_00_57, 8'd5, 4'd3, 56'h05_02_07_04_09_01_02}, // R3 multi tick
        '{56'h00_01_02_28_23_59_59, 8'd1, 4'd6, 56'h00_02_02_29_00_00_00}, // R6 year 00
        '{56'h05_01_01_01_09_09_59, 8'd1, 4'd3, 56'h05_01_01_01_09_10_00}  // R3 digit carry
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       xb = 1'b0;
    logic       xf = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_timekeeper #(.DIV_RATIO(DIV)) dut (
        .clk (clk), .rst_n (rst_n), .osc_en (osc_en),
        .xfer_begin (xb), .xfer_finish (xf),
        .buf_wr (wr), .buf_addr (addr), .buf_wdata (wd), .buf_rdata (rd)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic begin_x();
        @(negedge clk); xb = 1'b1;
        @(negedge clk); xb = 1'b0;
    endtask

    task automatic end_x();
        @(negedge clk); xf = 1'b1;
        @(negedge clk); xf = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wd = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a;
        #1 d = rd;
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            @(negedge clk); osc_en = 1'b1;
            repeat (n) @(negedge clk);
            osc_en = 1'b0;
        end
    endtask

    task automatic set_all(input logic [55:0] v);
        begin_x();
        for (int i = 0; i < 7; i++) write_reg(3'(i), v[i*8 +: 8]);
        end_x();
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        begin_x();
        for (int i = 0; i < 7; i++) begin
            read_reg(3'(i), b);
            v[i*8 +: 8] = b;
        end
        end_x();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [55:0] got;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset contents
        read_all(got);
        check("R2 reset values", got, 56'h00_01_01_01_00_00_00);

        // R9 write with no open transfer
        write_reg(3'd1, 8'h45);
        read_all(got);
        check("R9 idle write dropped", got, 56'h00_01_01_01_00_00_00);

        // R1 index 7 unmapped
        begin_x();
        write_reg(3'd7, 8'h5A);
        read_reg(3'd7, b);
        check("R1 index 7 reads zero", b, 8'h00);
        end_x();
        read_all(got);
        check("R1 index 7 write dropped", got, 56'h00_01_01_01_00_00_00);

        // Vector table: load, tick, read back (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            set_all(VECS[i].init);
            run(int'(VECS[i].n) * DIV);
            read_all(got);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), got, VECS[i].exp);
        end

        // R7 snapshot stays fixed while time moves
        set_all(56'h24_03_05_10_14_20_00);
        begin_x();
        run(2 * DIV);
        read_reg(3'd0, b);
        check("R7 read from snapshot", b, 8'h00);
        end_x();
        read_all(got);
        check("R7 running time advanced", got, 56'h24_03_05_10_14_20_02);

        // R8 partial write commits only what was written
        set_all(56'h24_03_05_10_14_20_00);
        begin_x();
        write_reg(3'd1, 8'h33);
        read_reg(3'd1, b);
        check("R8 buffer write visible", b, 8'h33);
        run(3 * DIV);
        end_x();
        read_all(got);
        check("R8 commit written only", got, 56'h24_03_05_10_14_33_03);

        // R10 seconds commit restarts the divider
        set_all(56'h24_03_05_10_14_20_00);
        run(DIV - 1);
        begin_x();
        write_reg(3'd0, 8'h10);
        end_x();
        run(DIV - 1);
        read_all(got);
        check("R10 no early tick", got, 56'h24_03_05_10_14_20_10);
        run(1);
        read_all(got);
        check("R10 tick after full period", got, 56'h24_03_05_10_14_20_11);

        // R11 halt flag freezes all counting
        set_all(56'h24_03_05_10_14_20_A0);
        run(3 * DIV);
        read_all(got);
        check("R11 halted", got, 56'h24_03_05_10_14_20_A0);
        begin_x();
        write_reg(3'd0, 8'h20);
        end_x();
        run(DIV);
        read_all(got);
        check("R11 resumed", got, 56'h24_03_05_10_14_20_21);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule